// File: doc/BRIEF.md
# Rotating Triple-Buffered Video Compositor

This block sits between a pixel generator running in a system clock domain and a display pipeline running in a separate audio/video clock domain. The generator pushes pixels one per valid cycle in row-major order. They are stored in three on-chip frame stores that take turns in three roles: being filled, holding the newest finished frame, and being shown. Because the shown frame is always complete and never the one being filled, the output never tears. This holds even though the panel is rotated a quarter turn and the source and output frame rates differ slightly. A slightly slower source makes the output repeat a frame now and then. A faster burst of source frames makes the output skip to the newest one.

On the output side, display timing logic pulses `frame_start` once per output frame and then requests pixels one at a time in the output raster order. The output raster is `SRC_H` pixels wide and `SRC_W` lines tall. The block fetches the matching source pixel along a column of the stored frame. It then fetches the overlay word for the same output position from a single overlay store. The overlay word holds a 15-bit colour and a 1-bit key. The block selects between the two pixels by that key and widens the result to 18 bits.

The role exchange at each output frame start uses a toggle request and acknowledge pair between the clocks. The caller must leave at least 30 output clock cycles between `frame_start` and the first pixel request of that frame, which normal vertical blanking provides.

Top module: `rotfb_compositor`

## Requirements
- R1: While either reset is low and right after it, `out_valid` is 0 and `out_pix` is 0.
- R2: A source frame becomes visible at the first `frame_start` after its last pixel is written. The source frame is `SRC_W*SRC_H` pixels, each `px_valid` cycle taking the next pixel in row-major order, x fastest.
- R3: The output pixel at output column `ox` (0..SRC_H-1) and output line `oy` (0..SRC_W-1) is the source pixel at x = `oy`, y = `SRC_H-1-ox`. Output columns advance fastest.
- R4: A pixel request sampled at clock edge k produces `out_valid` = 1 and the pixel after edge k+1. `out_valid` is 0 after edge k and after any edge not two edges after a request.
- R5: A `frame_start` with no source frame finished since the previous exchange shows the same frame again.
- R6: When several source frames finish between two exchanges, the newest of them is shown.
- R7: Source frames finishing while an output frame is being read never change the pixels of the frame being shown.
- R8: The overlay store is addressed by output position, index `oy*SRC_H+ox`. When bit 15 of that word is 1, the output is its colour in bits 14:0. When bit 15 is 0, the output is the source pixel and the overlay colour is ignored.
- R9: Colours are 15-bit with R in bits 14:10, G in 9:5 and B in 4:0. Each channel widens to 6 bits by appending its top bit, and the fields are packed R in 17:12, G in 11:6 and B in 5:0.
- R10: `frame_start` returns the output raster to position (0,0) even in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Source pixel clock |
| sys_rst_n | input | 1 | Synchronous active-low reset, source domain |
| px_valid | input | 1 | A source pixel is present this cycle |
| px_data | input | 15 | Source pixel colour |
| av_clk | input | 1 | Output clock |
| av_rst_n | input | 1 | Synchronous active-low reset, output domain |
| frame_start | input | 1 | Start of an output frame; exchanges buffers and rewinds the raster |
| pix_req | input | 1 | Request the next output pixel |
| ui_we | input | 1 | Overlay write strobe (output clock) |
| ui_addr | input | $clog2(SRC_W*SRC_H) | Overlay index, output raster order |
| ui_data | input | 16 | Overlay key (bit 15) and colour |
| out_valid | output | 1 | `out_pix` holds a requested pixel |
| out_pix | output | 18 | Composited, widened output pixel |

## Verification
A role index that goes wrong inside the exchange logic shows up at the first pixel read after the next `frame_start`. The symptom is a stale frame, a frame from the wrong generation, or one mixing two generations. The mid-frame writes of R7 expose a writer that targets the shown buffer within the same output frame. An addressing or rotation fault in the output path corrupts the first mismatched pixel two output edges after its request. The bench compares every pixel of every output frame it reads, so such a fault is seen at once. A wrong key polarity or widening rule appears on the first keyed or unkeyed pixel read.

// File: rtl/fb_pkg.sv
// Shared definitions for the rotating triple-buffered compositor.
// Assumes colours are 5:5:5 with red in the top field.
package fb_pkg;
    localparam int NUM_BUFS = 3;
    typedef logic [1:0] buf_idx_t;

    // Widen a 5:5:5 colour to 6:6:6 by appending each channel's top bit.
    function automatic logic [17:0] widen555(input logic [14:0] c);
        return {c[14:10], c[14], c[9:5], c[9], c[4:0], c[4]};
    endfunction
endpackage

// File: rtl/fb_bank.sv
// One dual-clock storage bank: one write port, one registered read port.
// Assumes addresses stay below DEPTH; contents are not reset.
module fb_bank #(
    parameter int DEPTH = 192,
    parameter int AW    = 8,
    parameter int DW    = 15
) (
    input  logic          wr_clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_clk,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [DEPTH];

    // Store a word on the write clock.
    always_ff @(posedge wr_clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Read a word every cycle on the read clock.
    always_ff @(posedge rd_clk) begin
        rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/fb_swap_ctl.sv
// Source-domain control: counts incoming pixels in row-major order and owns
// the three buffer roles (filling, newest, shown). It serves exchange requests
// from the output domain and answers with the index to show.
// Assumes take_tgl_a toggles only after the previous answer has been seen.
module fb_swap_ctl
    import fb_pkg::*;
#(
    parameter int SRC_W = 16,
    parameter int SRC_H = 12,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          px_valid,
    input  logic          take_tgl_a,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output buf_idx_t      wr_buf,
    output logic          ack_tgl,
    output buf_idx_t      ack_idx
);
    localparam int XW = (SRC_W > 1) ? $clog2(SRC_W) : 1;
    localparam int YW = (SRC_H > 1) ? $clog2(SRC_H) : 1;

    logic [XW-1:0] sx;
    logic [YW-1:0] sy;
    logic          frame_done;
    logic          tk_s1, tk_s2, tk_s3, take;
    buf_idx_t      wr_q, new_q, disp_q;
    logic          fresh_q;
    buf_idx_t      w1, n1, n2, d2;
    logic          f1, f2;

    assign frame_done = px_valid && sx == XW'(SRC_W-1) && sy == YW'(SRC_H-1);
    assign wr_en      = px_valid;
    assign wr_addr    = AW'(int'(sy) * SRC_W + int'(sx));
    assign wr_buf     = wr_q;
    assign take       = tk_s2 ^ tk_s3;

    // Row-major pixel position of the next incoming pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sx <= '0;
            sy <= '0;
        end else if (px_valid) begin
            if (sx == XW'(SRC_W-1)) begin
                sx <= '0;
                sy <= (sy == YW'(SRC_H-1)) ? '0 : sy + 1'b1;
            end else begin
                sx <= sx + 1'b1;
            end
        end
    end

    // Bring the exchange toggle into this clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) {tk_s1, tk_s2, tk_s3} <= '0;
        else        {tk_s1, tk_s2, tk_s3} <= {take_tgl_a, tk_s1, tk_s2};
    end

    // Next roles: a finished frame swaps first, then a pending take.
    always_comb begin
        w1 = wr_q;
        n1 = new_q;
        f1 = fresh_q;
        if (frame_done) begin
            w1 = new_q;
            n1 = wr_q;
            f1 = 1'b1;
        end
        d2 = disp_q;
        n2 = n1;
        f2 = f1;
        if (take && f1) begin
            d2 = n1;
            n2 = disp_q;
            f2 = 1'b0;
        end
    end

    // Role registers and the answer to the output domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 2'd0;
            new_q   <= 2'd1;
            disp_q  <= 2'd2;
            fresh_q <= 1'b0;
            ack_tgl <= 1'b0;
            ack_idx <= 2'd2;
        end else begin
            wr_q    <= w1;
            new_q   <= n2;
            disp_q  <= d2;
            fresh_q <= f2;
            if (take) begin
                ack_tgl <= ~ack_tgl;
                ack_idx <= d2;
            end
        end
    end

    // R7: the three roles always name three different buffers.
    a_r7_roles_distinct: assert property (@(posedge clk) disable iff (!rst_n)
        wr_q != new_q && wr_q != disp_q && new_q != disp_q && wr_q < 2'd3
        && new_q < 2'd3 && disp_q < 2'd3);

    // R7: the buffer being filled changes only at the end of a frame.
    a_r7_fill_held: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> $stable(wr_q));

    // R6: the fresh flag rises only after a frame was completed.
    a_r6_fresh_from_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fresh_q) |-> $past(frame_done));

    // R2: an answer is sent only in response to an exchange request.
    a_r2_ack_on_take: assert property (@(posedge clk) disable iff (!rst_n)
        ack_tgl != $past(ack_tgl) |-> $past(take));
endmodule

// File: rtl/fb_reader.sv
// Output-domain reader: requests a buffer exchange at each frame start,
// walks the output raster, forms the rotated source address and the overlay
// address, then mixes and widens the fetched pixels.
// Assumes pixel requests begin only after the exchange answer has returned.
module fb_reader
    import fb_pkg::*;
#(
    parameter int SRC_W = 16,
    parameter int SRC_H = 12,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          pix_req,
    input  logic          ack_tgl_a,
    input  buf_idx_t      ack_idx_a,
    output logic          take_tgl,
    output logic [AW-1:0] rd_addr,
    output logic [AW-1:0] ovl_addr,
    input  logic [14:0]   bank_q [NUM_BUFS],
    input  logic [15:0]   ovl_q,
    output logic          out_valid,
    output logic [17:0]   out_pix
);
    localparam int DEPTH = SRC_W * SRC_H;
    localparam int OXW   = (SRC_H > 1) ? $clog2(SRC_H) : 1;
    localparam int OYW   = (SRC_W > 1) ? $clog2(SRC_W) : 1;

    logic [OXW-1:0] ox;
    logic [OYW-1:0] oy;
    logic           ak_s1, ak_s2, ak_s3, ack_seen;
    buf_idx_t       disp_idx, sel1;
    logic           v1;
    logic [14:0]    src_px;

    assign ack_seen = ak_s2 ^ ak_s3;
    assign rd_addr  = AW'((SRC_H - 1 - int'(ox)) * SRC_W + int'(oy));
    assign ovl_addr = AW'(int'(oy) * SRC_H + int'(ox));
    assign src_px   = bank_q[sel1];

    // Bring the answer toggle into this clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) {ak_s1, ak_s2, ak_s3} <= '0;
        else        {ak_s1, ak_s2, ak_s3} <= {ack_tgl_a, ak_s1, ak_s2};
    end

    // Issue one exchange request per frame start when none is outstanding.
    always_ff @(posedge clk) begin
        if (!rst_n)                             take_tgl <= 1'b0;
        else if (frame_start && take_tgl == ak_s3) take_tgl <= ~take_tgl;
    end

    // Adopt the shown buffer index when the answer arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)        disp_idx <= 2'd2;
        else if (ack_seen) disp_idx <= ack_idx_a;
    end

    // Output raster position, columns fastest, rewound by frame start.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start) begin
            ox <= '0;
            oy <= '0;
        end else if (pix_req) begin
            if (ox == OXW'(SRC_H-1)) begin
                ox <= '0;
                oy <= (oy == OYW'(SRC_W-1)) ? '0 : oy + 1'b1;
            end else begin
                ox <= ox + 1'b1;
            end
        end
    end

    // Stage one: remember the request and the bank it reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1   <= 1'b0;
            sel1 <= 2'd0;
        end else begin
            v1   <= pix_req;
            sel1 <= disp_idx;
        end
    end

    // Stage two: keyed mix and widening of the fetched pixels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= v1;
            if (v1) out_pix <= ovl_q[15] ? widen555(ovl_q[14:0]) : widen555(src_px);
        end
    end

    // R4: a valid output is always two edges after a request.
    a_r4_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(pix_req, 2));

    // R2: the shown buffer changes only when an answer arrives.
    a_r2_disp_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_seen |=> $stable(disp_idx));

    // R2: exchange requests leave only at a frame start.
    a_r2_take_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        take_tgl != $past(take_tgl) |-> $past(frame_start));

    // R3: rotated and overlay addresses stay inside one frame.
    a_r3_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rd_addr) < DEPTH && int'(ovl_addr) < DEPTH);
endmodule

// File: rtl/rotfb_compositor.sv
// Top level: three source frame banks, one overlay bank, the source-domain
// role controller and the output-domain reader.
// Assumes at least 30 output cycles between frame_start and the first request.
module rotfb_compositor
    import fb_pkg::*;
#(
    parameter int SRC_W = 16,
    parameter int SRC_H = 12
) (
    input  logic                           sys_clk,
    input  logic                           sys_rst_n,
    input  logic                           px_valid,
    input  logic [14:0]                    px_data,
    input  logic                           av_clk,
    input  logic                           av_rst_n,
    input  logic                           frame_start,
    input  logic                           pix_req,
    input  logic                           ui_we,
    input  logic [$clog2(SRC_W*SRC_H)-1:0] ui_addr,
    input  logic [15:0]                    ui_data,
    output logic                           out_valid,
    output logic [17:0]                    out_pix
);
    localparam int DEPTH = SRC_W * SRC_H;
    localparam int AW    = $clog2(DEPTH);

    logic          wr_en;
    logic [AW-1:0] wr_addr;
    buf_idx_t      wr_buf;
    logic          take_tgl, ack_tgl;
    buf_idx_t      ack_idx;
    logic [AW-1:0] rd_addr, ovl_addr;
    logic [14:0]   bank_q [NUM_BUFS];
    logic [15:0]   ovl_q;

    fb_swap_ctl #(.SRC_W(SRC_W), .SRC_H(SRC_H), .AW(AW)) u_ctl (
        .clk(sys_clk), .rst_n(sys_rst_n), .px_valid(px_valid),
        .take_tgl_a(take_tgl), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_buf(wr_buf), .ack_tgl(ack_tgl), .ack_idx(ack_idx)
    );

    for (genvar i = 0; i < NUM_BUFS; i++) begin : g_bank
        fb_bank #(.DEPTH(DEPTH), .AW(AW), .DW(15)) u_bank (
            .wr_clk(sys_clk), .wr_en(wr_en && wr_buf == 2'(i)),
            .wr_addr(wr_addr), .wr_data(px_data),
            .rd_clk(av_clk), .rd_addr(rd_addr), .rd_data(bank_q[i])
        );
    end

    fb_bank #(.DEPTH(DEPTH), .AW(AW), .DW(16)) u_ovl (
        .wr_clk(av_clk), .wr_en(ui_we), .wr_addr(ui_addr), .wr_data(ui_data),
        .rd_clk(av_clk), .rd_addr(ovl_addr), .rd_data(ovl_q)
    );

    fb_reader #(.SRC_W(SRC_W), .SRC_H(SRC_H), .AW(AW)) u_rd (
        .clk(av_clk), .rst_n(av_rst_n), .frame_start(frame_start),
        .pix_req(pix_req), .ack_tgl_a(ack_tgl), .ack_idx_a(ack_idx),
        .take_tgl(take_tgl), .rd_addr(rd_addr), .ovl_addr(ovl_addr),
        .bank_q(bank_q), .ovl_q(ovl_q), .out_valid(out_valid), .out_pix(out_pix)
    );
endmodule

// File: tb/sim_rotfb_compositor.sv
module sim_rotfb_compositor;
    localparam int W  = 16;
    localparam int H  = 12;
    localparam int N  = W * H;
    localparam int AW = $clog2(N);

    // Scenario table: {frames to write, expected generation shown}.
    localparam logic [15:0] VEC [4] = '{
        {8'd1, 8'd1},   // R2/R3: first frame appears
        {8'd0, 8'd1},   // R5: nothing new, repeat
        {8'd3, 8'd4},   // R6: three finish, newest shown
        {8'd1, 8'd5}    // R2: one more
    };

    logic sys_clk = 0, av_clk = 0;
    logic sys_rst_n = 0, av_rst_n = 0;
    logic px_valid = 0, frame_start = 0, pix_req = 0, ui_we = 0;
    logic [14:0] px_data = '0;
    logic [AW-1:0] ui_addr = '0;
    logic [15:0] ui_data = '0;
    logic out_valid;
    logic [17:0] out_pix;

    int compared = 0, mismatched = 0, next_id = 1;
    bit finished = 0;
    logic [15:0] ovl_model [N];

    always #4 av_clk = ~av_clk;
    always #5.5 sys_clk = ~sys_clk;

    rotfb_compositor #(.SRC_W(W), .SRC_H(H)) u0 (
        .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .px_valid(px_valid),
        .px_data(px_data), .av_clk(av_clk), .av_rst_n(av_rst_n),
        .frame_start(frame_start), .pix_req(pix_req), .ui_we(ui_we),
        .ui_addr(ui_addr), .ui_data(ui_data), .out_valid(out_valid), .out_pix(out_pix)
    );

    function automatic logic [14:0] pat(int id, int sx, int sy);
        return {5'(id), 5'(sx), 5'(sy)};
    endfunction

    function automatic logic [17:0] to666(logic [14:0] c);
        return {c[14:10], c[14], c[9:5], c[9], c[4:0], c[4]};
    endfunction

    task automatic check(string tag, bit ok, logic [18:0] got, logic [18:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic write_frame();
        for (int sy = 0; sy < H; sy++)
            for (int sx = 0; sx < W; sx++) begin
                @(negedge sys_clk);
                px_valid = 1;
                px_data  = pat(next_id, sx, sy);
            end
        @(negedge sys_clk) px_valid = 0;
        next_id++;
        repeat (5) @(negedge sys_clk);
    endtask

    task automatic start_frame();
        @(negedge av_clk) frame_start = 1;
        @(negedge av_clk) frame_start = 0;
        repeat (30) @(negedge av_clk);
    endtask

    task automatic ui_write(int idx, logic [15:0] v);
        @(negedge av_clk);
        ui_we = 1; ui_addr = AW'(idx); ui_data = v;
        @(negedge av_clk) ui_we = 0;
        ovl_model[idx] = v;
    endtask

    // R3/R8/R9: fetch the pixel at (ox,oy) and compare with the model.
    task automatic read_px(int ox, int oy, int id, string tag);
        logic [15:0] ov;
        logic [17:0] e;
        ov = ovl_model[oy * H + ox];
        e  = ov[15] ? to666(ov[14:0]) : to666(pat(id, oy, H - 1 - ox));
        @(negedge av_clk) pix_req = 1;
        @(negedge av_clk) pix_req = 0;
        @(negedge av_clk);
        check(tag, out_valid === 1'b1 && out_pix === e, {out_valid, out_pix}, {1'b1, e});
    endtask

    task automatic read_frame(int id, string tag);
        for (int oy = 0; oy < W; oy++)
            for (int ox = 0; ox < H; ox++)
                read_px(ox, oy, id, tag);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (150000) @(posedge av_clk);
        if (!finished) begin
            finished = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog got=running exp=done");
            summary();
            $finish;
        end
    end

    initial begin
        string tg;
        repeat (4) @(negedge sys_clk);
        @(negedge av_clk);
        check("R1 in reset", out_valid === 1'b0 && out_pix === '0, {out_valid, out_pix}, '0);
        sys_rst_n = 1;
        av_rst_n  = 1;
        repeat (3) @(negedge av_clk);
        check("R1 after reset", out_valid === 1'b0 && out_pix === '0, {out_valid, out_pix}, '0);

        for (int i = 0; i < N; i++) ui_write(i, 16'h0000);

        // Table walk: frames written, exchange, full rotated readout.
        for (int s = 0; s < 4; s++) begin
            for (int f = 0; f < int'(VEC[s][15:8]); f++) write_frame();
            start_frame();
            case (s)
                0: tg = "R2 R3 first frame";
                1: tg = "R5 repeat";
                2: tg = "R6 newest";
                default: tg = "R2 next";
            endcase
            read_frame(int'(VEC[s][7:0]), tg);
        end

        // R4: exact latency of one request.
        start_frame();
        @(negedge av_clk) pix_req = 1;
        @(negedge av_clk) pix_req = 0;
        check("R4 not yet valid", out_valid === 1'b0, {18'h0, out_valid}, 19'h0);
        @(negedge av_clk);
        check("R4 valid", out_valid === 1'b1 && out_pix === to666(pat(5, 0, H - 1)),
              {out_valid, out_pix}, {1'b1, to666(pat(5, 0, H - 1))});
        @(negedge av_clk);
        check("R4 drops", out_valid === 1'b0, {18'h0, out_valid}, 19'h0);

        // R10: rewind mid-frame.
        for (int ox = 1; ox < 6; ox++) read_px(ox, 0, 5, "R10 walk");
        start_frame();
        read_px(0, 0, 5, "R10 rewound");

        // R7: frames finishing mid-readout leave the shown frame intact.
        write_frame();                    // generation 6
        start_frame();
        for (int k = 0; k < N / 2; k++) read_px(k % H, k / H, 6, "R7 first half");
        write_frame();                    // 7
        write_frame();                    // 8
        for (int k = N / 2; k < N; k++) read_px(k % H, k / H, 6, "R7 second half");
        start_frame();
        read_frame(8, "R7 newest after");

        // R8/R9: keyed overlay words and widening.
        ui_write(0, 16'hC210);            // key, colour 0x4210
        ui_write(5, 16'hFFFF);            // key, colour 0x7FFF
        ui_write(7, 16'h1234);            // no key: colour ignored
        ui_write(N - 1, 16'h8001);
        start_frame();
        read_frame(8, "R8 overlay mix");
        start_frame();
        @(negedge av_clk) pix_req = 1;
        @(negedge av_clk) pix_req = 0;
        @(negedge av_clk);
        check("R9 0x4210 widening", out_pix === 18'h21861, {1'b0, out_pix}, 19'h21861);
        for (int ox = 1; ox < 5; ox++) read_px(ox, 0, 8, "R8 walk");
        @(negedge av_clk) pix_req = 1;
        @(negedge av_clk) pix_req = 0;
        @(negedge av_clk);
        check("R9 white", out_pix === 18'h3FFFF, {1'b0, out_pix}, 19'h3FFFF);
        read_px(6, 0, 8, "R8 after white");
        read_px(7, 0, 8, "R8 unkeyed ignored");

        if (!finished) begin
            finished = 1;
            summary();
            $finish;
        end
    end
endmodule